// File: doc/BRIEF.md
# Packed Unsigned Multiply-High Unit

This execution unit takes two packed operands split into 16-bit unsigned lanes. It multiplies matching lanes of the destination operand and the source operand into full 32-bit products. Each lane keeps only the upper 16 bits of its product, and that value goes back into the same lane position of the result. The surrounding datapath writes the result back to the destination register. The operation sets no status flags and raises no numeric exceptions.

A mode input selects the operand width for each operation. The narrow form works on four lanes (64 bits). The wide form works on eight lanes (128 bits). The instruction decoder drives this input from the opcode form: the two-byte opcode alone gives the narrow form, and the same opcode with the operand-size prefix gives the wide form.

Operands enter through a valid/ready handshake. A two-stage pipeline produces the result with a valid flag. The pipeline stalls as a whole when the consumer holds off the output.

Top module: `mulhi_simd_unit`

## Requirements
- R1: For every active lane, the result lane equals bits 31:16 of the unsigned 32-bit product of the two input lanes. For example, 0xFFFF times 0xFFFF gives 0xFFFE, and 0x8000 times 0x0002 gives 0x0001.
- R2: Lane i occupies bits [16i+15:16i] of `dstIn`, of `srcIn` and of `resOut`. Lanes are computed independently, and no carry passes between them.
- R3: `wideMode`=1 (prefixed form) processes eight lanes across bits 127:0. `wideMode`=0 (unprefixed form) processes four lanes across bits 63:0 and drives `resOut[127:64]` to zero, whatever the upper input bits hold.
- R4: When `outReady` stays high, `outValid` rises exactly two clock cycles after an accepted input.
- R5: An input is accepted only in a cycle where both `inValid` and `inReady` are high. A cycle that does not accept an input produces no result.
- R6: `inReady` is low exactly when `outValid` is high and `outReady` is low. Otherwise it is high.
- R7: While `outValid` is high and `outReady` is low, `outValid`, `resOut` and the whole pipeline hold their state.
- R8: A synchronous active-high `rst` clears both pipeline valid bits, so `outValid` is low in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands and mode present |
| inReady | output | 1 | Unit can accept operands |
| wideMode | input | 1 | 1 = eight lanes, 0 = four lanes |
| dstIn | input | 128 | Destination operand lanes |
| srcIn | input | 128 | Source operand lanes |
| outValid | output | 1 | Result is present |
| outReady | input | 1 | Consumer takes the result |
| resOut | output | 128 | Packed high halves of the products |

## Verification
Two events can fall in the same cycle: accepting a new operand and releasing or holding a stalled result. The bench drives `inValid` and a random `outReady` against each other for thousands of cycles and switches the mode at random. This places new inputs on the exact cycles where a stall starts or ends. Every cycle, a behavioural reference model predicts `inReady`, `outValid` and `resOut`, and the bench compares the design's outputs to it. A result that is lost, duplicated or taken from the wrong operation during a stall shows up as a mismatch.

// File: rtl/mulhi_pkg.sv
package mulhi_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic advance;  // whole pipeline moves one stage
    logic load;     // an operand is accepted this cycle
  } mhStrobe_t;
endpackage

// File: rtl/mulhi_ctrl.sv
module mulhi_ctrl
  import mulhi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output mhStrobe_t  strobe
);
  logic s1Valid;
  logic outValidQ;
  logic stalled;

  assign stalled        = outValidQ && !outReady;
  assign strobe.advance = !stalled;
  assign strobe.load    = inValid && !stalled;
  assign inReady        = !stalled;
  assign outValid       = outValidQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid   <= 1'b0;
      outValidQ <= 1'b0;
    end else if (strobe.advance) begin
      s1Valid   <= strobe.load;
      outValidQ <= s1Valid;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> outValid); // R7
  AST_READY_LOW_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |-> !inReady); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!outValid && !s1Valid)); // R8
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
    (!inValid && inReady) |=> !s1Valid); // R5
endmodule

// File: rtl/mulhi_dpath.sv
module mulhi_dpath
  import mulhi_pkg::*;
#(
  parameter int LANE_W       = 16,
  parameter int LANES        = 8,
  parameter int NARROW_LANES = 4
) (
  input  logic                      clk,
  input  mhStrobe_t                 strobe,
  input  logic                      wideIn,
  input  logic [LANE_W*LANES-1:0]   dstIn,
  input  logic [LANE_W*LANES-1:0]   srcIn,
  output logic [LANE_W*LANES-1:0]   resOut,
  output logic                      wideOut
);
  localparam int PROD_W = 2 * LANE_W;

  logic [PROD_W-1:0] prodQ   [LANES];
  logic [LANE_W-1:0] laneRes [LANES];
  logic              wideS1;
  logic              wideS2;

  always_ff @(posedge clk) begin
    if (strobe.advance) begin
      wideS1 <= wideIn;
      wideS2 <= wideS1;
    end
  end
  assign wideOut = wideS2;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    // stage one: full unsigned product
    always_ff @(posedge clk) begin
      if (strobe.advance)
        prodQ[g] <= PROD_W'(dstIn[g*LANE_W +: LANE_W]) *
                    PROD_W'(srcIn[g*LANE_W +: LANE_W]);
    end
    // stage two: upper half, masked for lanes outside the narrow form
    if (g < NARROW_LANES) begin : gLow
      always_ff @(posedge clk) begin
        if (strobe.advance) laneRes[g] <= prodQ[g][PROD_W-1:LANE_W];
      end
    end else begin : gHigh
      always_ff @(posedge clk) begin
        if (strobe.advance)
          laneRes[g] <= wideS1 ? prodQ[g][PROD_W-1:LANE_W] : '0;
      end
    end
    assign resOut[g*LANE_W +: LANE_W] = laneRes[g];
  end
endmodule

// File: rtl/mulhi_simd_unit.sv
module mulhi_simd_unit
  import mulhi_pkg::*;
#(
  parameter int LANE_W       = 16,
  parameter int LANES        = 8,
  parameter int NARROW_LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic                     wideMode,
  input  logic [LANE_W*LANES-1:0]  dstIn,
  input  logic [LANE_W*LANES-1:0]  srcIn,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [LANE_W*LANES-1:0]  resOut
);
  localparam int DATA_W   = LANE_W * LANES;
  localparam int NARROW_W = LANE_W * NARROW_LANES;

  mhStrobe_t strobe;
  logic      wideOut;

  mulhi_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  mulhi_dpath #(
    .LANE_W       (LANE_W),
    .LANES        (LANES),
    .NARROW_LANES (NARROW_LANES)
  ) u_dpath (
    .clk     (clk),
    .strobe  (strobe),
    .wideIn  (wideMode),
    .dstIn   (dstIn),
    .srcIn   (srcIn),
    .resOut  (resOut),
    .wideOut (wideOut)
  );

  AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ((inValid && inReady) ##1 inReady) |=> outValid); // R4
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (outValid && !wideOut) |-> (resOut[DATA_W-1:NARROW_W] == '0)); // R3
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> $stable(resOut)); // R7
endmodule

// File: tb/sim_mulhi_simd_unit.sv
`timescale 1ns/1ps
module sim_mulhi_simd_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic wideMode = 1'b0;
  logic outReady = 1'b1;
  logic [127:0] dstIn = '0;
  logic [127:0] srcIn = '0;
  logic inReady, outValid;
  logic [127:0] resOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mulhi_simd_unit u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .wideMode(wideMode), .dstIn(dstIn), .srcIn(srcIn),
    .outValid(outValid), .outReady(outReady), .resOut(resOut)
  );

  // behavioural reference
  function automatic logic [127:0] refCalc(logic [127:0] d, logic [127:0] s, logic w);
    logic [127:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      if (w || i < 4) begin
        longint unsigned p = longint'(d[16*i +: 16]) * longint'(s[16*i +: 16]);
        r[16*i +: 16] = 16'(p >> 16);
      end
    end
    return r;
  endfunction

  logic         mS1v = 1'b0, mOv = 1'b0, mS1w = 1'b0, mOw = 1'b0;
  logic [127:0] mS1r = '0, mOr = '0;

  always @(posedge clk) begin
    if (rst) begin
      mS1v = 1'b0;
      mOv  = 1'b0;
    end else if (!(mOv && !outReady)) begin
      mOv  = mS1v;
      mOr  = mS1r;
      mOw  = mS1w;
      mS1v = inValid;
      mS1w = wideMode;
      mS1r = refCalc(dstIn, srcIn, wideMode);
    end
  end

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare all outputs against the model, away from the edge
  task automatic compareNow();
    chk("R6 inReady", 128'(inReady), 128'(!(mOv && !outReady)));
    chk("R5 outValid", 128'(outValid), 128'(mOv));
    if (mOv) begin
      chk("R1 lower lanes", 128'(resOut[63:0]), 128'(mOr[63:0]));
      if (mOw) chk("R2 upper lanes", 128'(resOut[127:64]), 128'(mOr[127:64]));
      else     chk("R3 upper zero", 128'(resOut[127:64]), 128'(0));
    end
  endtask

  task automatic step(logic v, logic w, logic [127:0] d, logic [127:0] s, logic ordy);
    @(negedge clk);
    compareNow();
    inValid = v; wideMode = w; dstIn = d; srcIn = s; outReady = ordy;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    // reset
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 outValid after reset", 128'(outValid), 128'(0));
    chk("R6 inReady after reset", 128'(inReady), 128'(1));

    // R1 extremes, wide form, then idle
    step(1, 1, {8{16'hFFFF}}, {8{16'hFFFF}}, 1);
    step(0, 0, '0, '0, 1);
    step(0, 0, '0, '0, 1);
    chk("R4 valid two cycles after accept", 128'(outValid), 128'(1));
    chk("R1 FFFF*FFFF", 128'(resOut), {8{16'hFFFE}});
    step(0, 0, '0, '0, 1);
    chk("R5 no result without input", 128'(outValid), 128'(0));

    // R2 distinct per-lane values
    step(1, 1, {16'h8000,16'h0002,16'h1234,16'h0100,16'hFFFF,16'h0000,16'h4000,16'h00FF},
               {16'h0002,16'h8000,16'h5678,16'h0100,16'h0001,16'hFFFF,16'h0004,16'h0101}, 1);
    step(0, 0, '0, '0, 1);
    step(0, 0, '0, '0, 1);
    chk("R2 lane placement", 128'(resOut),
        {16'h0001,16'h0001,16'h0626,16'h0001,16'h0000,16'h0000,16'h0001,16'h0000});

    // R3 narrow form ignores upper input bits
    step(1, 0, {8{16'hFFFF}}, {8{16'hFFFF}}, 1);
    step(0, 1, '0, '0, 1);
    step(0, 1, '0, '0, 1);
    chk("R3 narrow result", 128'(resOut), {64'h0, {4{16'hFFFE}}});

    // R7 stall with input pending
    step(1, 1, {8{16'h2000}}, {8{16'h0010}}, 1);
    step(1, 1, {8{16'h4000}}, {8{16'h0010}}, 0);
    for (int k = 0; k < 5; k++) step(1, 1, rnd128(), rnd128(), 0);
    chk("R7 held result", 128'(resOut), {8{16'h0002}});
    chk("R6 ready low in stall", 128'(inReady), 128'(0));
    step(0, 0, '0, '0, 1);
    step(0, 0, '0, '0, 1);
    step(0, 0, '0, '0, 1);

    // random mix of modes, gaps and stalls
    for (int k = 0; k < 3000; k++)
      step(($urandom % 4) != 0, $urandom % 2, rnd128(), rnd128(), ($urandom % 10) < 7);

    // R8 reset in mid-stream
    step(1, 1, rnd128(), rnd128(), 1);
    step(1, 1, rnd128(), rnd128(), 1);
    rst = 1'b1;
    step(0, 0, '0, '0, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 cleared mid-stream", 128'(outValid), 128'(0));
    step(0, 0, '0, '0, 1);
    step(0, 0, '0, '0, 1);
    finishRun();
  end
endmodule